// File: doc/BRIEF.md
# Warp Divergence Reconvergence Stack

This block tracks control-flow divergence for a single warp of 32 lanes. Each cycle it receives one decoded control event together with the warp's current active-lane mask, the address of the next sequential instruction and, where relevant, a target address. It returns the address and lane mask the warp should run with next. A single last-in-first-out store of tokens serves three purposes: reconvergence points ahead of conditional regions, the deferred path of a split branch, and subroutine returns. Each token carries an address, a two-bit kind and a lane mask.

A sync event records where the paths of a conditional region meet again. A predicated branch whose lanes disagree runs the taken lanes first and records the remaining lanes with the fall-through address. A join either switches to that deferred path or, once both paths are done, brings back the mask from before the split. Call and return use the same store. Overflow and underflow are reported on the same cycle as the event that caused them, and in either case the store is left untouched.

Top module: `simt_reconv_stack`

## Requirements
- R1: After reset the token store is empty, so a join (event code 3) issued as the first event raises `underflow`.
- R2: A sync event (code 1) saves a reconvergence token holding `tgt_pc` and `cur_mask`. The outputs are `seq_pc` and `cur_mask`.
- R3: A branch event (code 2) in which some active lanes are taken and some are not drives `next_pc = tgt_pc` and `next_mask = pred_mask & cur_mask`. It also saves a deferred-path token holding `seq_pc` and `~pred_mask & cur_mask`. In every case, for event codes 0, 1, 2 and 4, `next_mask` holds no lane outside `cur_mask`.
- R4: A branch whose active lanes all agree saves no token. If every lane is taken, the outputs are `tgt_pc` and `cur_mask`. If no lane is taken, they are `seq_pc` and `cur_mask`.
- R5: A join whose newest token is a deferred-path token outputs that token's address and mask and removes the token.
- R6: A join whose newest token is a reconvergence token outputs `seq_pc` with the token's mask and removes the token.
- R7: A call event (code 4) saves a return token holding `seq_pc` and `cur_mask` and outputs `tgt_pc` with `cur_mask`. A return event (code 5) outputs the newest token's address and mask and removes the token.
- R8: A save attempted while DEPTH (default 16) tokens are held raises `overflow` and leaves the stored tokens unchanged. The outputs follow the event's normal rule.
- R9: A join or return with no tokens held raises `underflow` and outputs `seq_pc` with `cur_mask`. `overflow` and `underflow` are never high together.
- R10: With no event (code 0) the outputs are `seq_pc` and `cur_mask`, and the stored tokens do not change.
- R11: A join whose newest token is a return token removes nothing and outputs `seq_pc` with `cur_mask`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_kind | input | 3 | Event: 0 none, 1 sync, 2 branch, 3 join, 4 call, 5 return |
| cur_pc | input | PC_W | Address of the current control instruction |
| seq_pc | input | PC_W | Address of the next sequential instruction |
| tgt_pc | input | PC_W | Branch, call or reconvergence target |
| cur_mask | input | LANES | Lanes active now |
| pred_mask | input | LANES | Per-lane branch predicate |
| next_pc | output | PC_W | Address for the warp's next instruction |
| next_mask | output | LANES | Lane mask for the warp's next instruction |
| overflow | output | 1 | Save refused because the store is full |
| underflow | output | 1 | Removal refused because the store is empty |

## Verification
The assertions rely on two conditions. `ev_kind` holds only codes 0 to 5, and reset is low from time zero until the inputs are defined. The bench keeps to both. It holds reset through the first edges, drives exactly one defined event per clock from the falling edge, and returns `ev_kind` to 0 after the last event. Because every event takes effect at a single rising edge, each scenario is a short fixed sequence whose expected outputs follow directly from the requirement tables. The scenarios cover a nested split and rejoin, uniform branches, a call interleaved with a join, and filling the store past its depth.

// File: rtl/simt_reconv_pkg.sv
package simt_reconv_pkg;
   typedef enum logic [2:0] {
      EV_NONE = 3'd0,
      EV_SYNC = 3'd1,
      EV_BRA  = 3'd2,
      EV_JOIN = 3'd3,
      EV_CALL = 3'd4,
      EV_RET  = 3'd5
   } ev_kind_e;

   typedef enum logic [1:0] {
      TK_SYNC = 2'd0,
      TK_DIV  = 2'd1,
      TK_CALL = 2'd2
   } tok_kind_e;

   localparam int unsigned TOK_KIND_W = 2;
endpackage

// File: rtl/simt_tok_lifo.sv
module simt_tok_lifo #(
   parameter int unsigned W     = 66,
   parameter int unsigned DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic         pop,
   input  logic [W-1:0] push_data,
   output logic [W-1:0] top_data,
   output logic         empty,
   output logic         full
);
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);
   localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("simt_tok_lifo: DEPTH must be at least 2");
      end
      if (W < 3) begin : g_bad_width
         $error("simt_tok_lifo: W too small for a token");
      end
   endgenerate

   logic [W-1:0]     mem [DEPTH];
   logic [CNT_W-1:0] cnt;
   logic [IDX_W-1:0] wr_idx;
   logic [IDX_W-1:0] rd_idx;
   logic             push_ok;
   logic             pop_ok;

   assign empty    = (cnt == '0);
   assign full     = (cnt == CNT_W'(DEPTH));
   assign wr_idx   = IDX_W'(cnt);
   assign rd_idx   = IDX_W'(cnt - 1'b1);
   assign push_ok  = push && !full;
   assign pop_ok   = pop && !empty && !push;
   assign top_data = empty ? '0 : mem[rd_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (push_ok) begin
         cnt <= cnt + 1'b1;
      end else if (pop_ok) begin
         cnt <= cnt - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok) begin
         mem[wr_idx] <= push_data;
      end
   end

   // R2: a successful save shows up as the newest token one edge later
   p_push_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !full) |=> (top_data == $past(push_data)));

   // R8: a refused save leaves the newest token as it was
   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full) |=> (top_data == $past(top_data)) && full);

   // R8: occupancy never exceeds the configured depth
   p_depth_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(DEPTH));

   // R9: a refused removal leaves the store empty
   p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty) |=> empty);

   // R10: with no request the occupancy holds
   p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!push && !pop) |=> $stable(cnt));

   // selector never asks for both in one cycle
   p_one_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(push && pop));
endmodule

// File: rtl/simt_path_sel.sv
module simt_path_sel
   import simt_reconv_pkg::*;
#(
   parameter int unsigned PC_W  = 32,
   parameter int unsigned LANES = 32,
   parameter int unsigned TOK_W = PC_W + TOK_KIND_W + LANES
) (
   input  ev_kind_e           kind,
   input  logic [PC_W-1:0]    seq_pc,
   input  logic [PC_W-1:0]    tgt_pc,
   input  logic [LANES-1:0]   cur_mask,
   input  logic [LANES-1:0]   pred_mask,
   input  logic [TOK_W-1:0]   top_tok,
   input  logic               empty,
   output logic [PC_W-1:0]    next_pc,
   output logic [LANES-1:0]   next_mask,
   output logic               push_req,
   output logic               pop_req,
   output logic [TOK_W-1:0]   push_tok
);
   logic [LANES-1:0] taken;
   logic [LANES-1:0] stay;
   logic [PC_W-1:0]  top_addr;
   logic [LANES-1:0] top_mask;
   tok_kind_e        top_kind;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign taken[l] = pred_mask[l] & cur_mask[l];
      assign stay[l]  = ~pred_mask[l] & cur_mask[l];
   end

   assign top_mask = top_tok[LANES-1:0];
   assign top_kind = tok_kind_e'(top_tok[LANES +: TOK_KIND_W]);
   assign top_addr = top_tok[LANES + TOK_KIND_W +: PC_W];

   always_comb begin
      next_pc   = seq_pc;
      next_mask = cur_mask;
      push_req  = 1'b0;
      pop_req   = 1'b0;
      push_tok  = '0;
      case (kind)
         EV_SYNC: begin
            push_req = 1'b1;
            push_tok = {tgt_pc, TK_SYNC, cur_mask};
         end
         EV_BRA: begin
            if ((|taken) && (|stay)) begin
               push_req  = 1'b1;
               push_tok  = {seq_pc, TK_DIV, stay};
               next_pc   = tgt_pc;
               next_mask = taken;
            end else if (|taken) begin
               next_pc = tgt_pc;
            end
         end
         EV_JOIN: begin
            if (empty) begin
               pop_req = 1'b1;
            end else if (top_kind == TK_DIV) begin
               pop_req   = 1'b1;
               next_pc   = top_addr;
               next_mask = top_mask;
            end else if (top_kind == TK_SYNC) begin
               pop_req   = 1'b1;
               next_mask = top_mask;
            end
         end
         EV_CALL: begin
            push_req = 1'b1;
            push_tok = {seq_pc, TK_CALL, cur_mask};
            next_pc  = tgt_pc;
         end
         EV_RET: begin
            pop_req = 1'b1;
            if (!empty) begin
               next_pc   = top_addr;
               next_mask = top_mask;
            end
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
   import simt_reconv_pkg::*;
#(
   parameter int unsigned PC_W  = 32,
   parameter int unsigned LANES = 32,
   parameter int unsigned DEPTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       ev_kind,
   input  logic [PC_W-1:0]  cur_pc,
   input  logic [PC_W-1:0]  seq_pc,
   input  logic [PC_W-1:0]  tgt_pc,
   input  logic [LANES-1:0] cur_mask,
   input  logic [LANES-1:0] pred_mask,
   output logic [PC_W-1:0]  next_pc,
   output logic [LANES-1:0] next_mask,
   output logic             overflow,
   output logic             underflow
);
   localparam int unsigned TOK_W = PC_W + TOK_KIND_W + LANES;

   generate
      if (LANES < 1 || PC_W < 2) begin : g_bad_cfg
         $error("simt_reconv_stack: LANES and PC_W out of range");
      end
   endgenerate

   logic [TOK_W-1:0] push_tok;
   logic [TOK_W-1:0] top_tok;
   logic             push_req;
   logic             pop_req;
   logic             empty;
   logic             full;
   logic [PC_W-1:0]  unused_pc;

   assign unused_pc = cur_pc;

   simt_path_sel #(.PC_W(PC_W), .LANES(LANES), .TOK_W(TOK_W)) sel_i (
      .kind      (ev_kind_e'(ev_kind)),
      .seq_pc    (seq_pc),
      .tgt_pc    (tgt_pc),
      .cur_mask  (cur_mask),
      .pred_mask (pred_mask),
      .top_tok   (top_tok),
      .empty     (empty),
      .next_pc   (next_pc),
      .next_mask (next_mask),
      .push_req  (push_req),
      .pop_req   (pop_req),
      .push_tok  (push_tok)
   );

   simt_tok_lifo #(.W(TOK_W), .DEPTH(DEPTH)) lifo_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push_req),
      .pop       (pop_req),
      .push_data (push_tok),
      .top_data  (top_tok),
      .empty     (empty),
      .full      (full)
   );

   assign overflow  = push_req && full;
   assign underflow = pop_req && empty;

   // R3: events that do not restore a token never widen the lane set
   p_mask_subset_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_kind == 3'd0 || ev_kind == 3'd1 || ev_kind == 3'd2 || ev_kind == 3'd4)
      |-> ((next_mask & ~cur_mask) == '0));

   // R9: the two error flags are exclusive
   p_flag_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(overflow && underflow));

   // R10: idle cycles pass the sequential address through
   p_idle_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_kind == 3'd0) |-> (next_pc == seq_pc && next_mask == cur_mask && !overflow && !underflow));
endmodule

// File: tb/simt_reconv_stack_tb_top.sv
module simt_reconv_stack_tb_top;
   localparam logic [2:0] K_NONE = 3'd0;
   localparam logic [2:0] K_SYNC = 3'd1;
   localparam logic [2:0] K_BRA  = 3'd2;
   localparam logic [2:0] K_JOIN = 3'd3;
   localparam logic [2:0] K_CALL = 3'd4;
   localparam logic [2:0] K_RET  = 3'd5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  ev_kind = K_NONE;
   logic [31:0] cur_pc = '0;
   logic [31:0] seq_pc = '0;
   logic [31:0] tgt_pc = '0;
   logic [31:0] cur_mask = '0;
   logic [31:0] pred_mask = '0;
   logic [31:0] next_pc;
   logic [31:0] next_mask;
   logic        overflow;
   logic        underflow;

   always #2 clk = ~clk;

   simt_reconv_stack dut_i (
      .clk(clk), .rst_n(rst_n), .ev_kind(ev_kind), .cur_pc(cur_pc),
      .seq_pc(seq_pc), .tgt_pc(tgt_pc), .cur_mask(cur_mask),
      .pred_mask(pred_mask), .next_pc(next_pc), .next_mask(next_mask),
      .overflow(overflow), .underflow(underflow)
   );

   typedef struct {
      logic [31:0] pc;
      logic [31:0] mask;
      logic        ovf;
      logic        udf;
      string       tag;
   } exp_t;

   exp_t q[$];
   exp_t e;
   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;

   task automatic drive(input logic [2:0] k, input logic [31:0] cm, input logic [31:0] pm,
                        input logic [31:0] sq, input logic [31:0] tg,
                        input logic [31:0] epc, input logic [31:0] emask,
                        input logic eo, input logic eu, input string tag);
      @(negedge clk);
      ev_kind   = k;
      cur_mask  = cm;
      pred_mask = pm;
      seq_pc    = sq;
      cur_pc    = sq - 32'd4;
      tgt_pc    = tg;
      q.push_back('{epc, emask, eo, eu, tag});
   endtask

   // monitor: compares outputs against queued expectations mid-cycle
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (q.size() > 0) begin
            e = q.pop_front();
            checks++;
            if (next_pc !== e.pc || next_mask !== e.mask ||
                overflow !== e.ovf || underflow !== e.udf) begin
               errors++;
               $display("FAIL %s: pc=%h mask=%h ovf=%b udf=%b expected pc=%h mask=%h ovf=%b udf=%b",
                        e.tag, next_pc, next_mask, overflow, underflow,
                        e.pc, e.mask, e.ovf, e.udf);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state, idle pass-through then join on empty store
      drive(K_NONE, 32'hF0F0F0F0, 0, 32'h100, 0, 32'h100, 32'hF0F0F0F0, 0, 0, "R1 R10 idle after reset");
      drive(K_JOIN, 32'hF0F0F0F0, 0, 32'h104, 0, 32'h104, 32'hF0F0F0F0, 0, 1, "R1 join on empty");
      drive(K_RET,  32'h0000000F, 0, 32'h108, 0, 32'h108, 32'h0000000F, 0, 1, "R9 return on empty");

      // R2 R3 R5 R6: split and rejoin
      drive(K_SYNC, 32'hFFFFFFFF, 0, 32'h104, 32'h200, 32'h104, 32'hFFFFFFFF, 0, 0, "R2 sync");
      drive(K_NONE, 32'hFFFFFFFF, 0, 32'h108, 0, 32'h108, 32'hFFFFFFFF, 0, 0, "R10 idle mid region");
      drive(K_BRA,  32'hFFFFFFFF, 32'h0000FFFF, 32'h10C, 32'h300, 32'h300, 32'h0000FFFF, 0, 0, "R3 divergent branch");
      drive(K_JOIN, 32'h0000FFFF, 0, 32'h310, 0, 32'h10C, 32'hFFFF0000, 0, 0, "R5 join to deferred path");
      drive(K_JOIN, 32'hFFFF0000, 0, 32'h200, 0, 32'h200, 32'hFFFFFFFF, 0, 0, "R6 join restores mask");
      drive(K_JOIN, 32'hFFFFFFFF, 0, 32'h204, 0, 32'h204, 32'hFFFFFFFF, 0, 1, "R5 R6 both tokens popped");

      // R4: uniform branches save nothing
      drive(K_SYNC, 32'h0F0F0F0F, 0, 32'h110, 32'h400, 32'h110, 32'h0F0F0F0F, 0, 0, "R2 sync second region");
      drive(K_BRA,  32'h0F0F0F0F, 32'hFFFFFFFF, 32'h114, 32'h500, 32'h500, 32'h0F0F0F0F, 0, 0, "R4 all taken");
      drive(K_BRA,  32'h0F0F0F0F, 32'hF0F0F0F0, 32'h504, 32'h600, 32'h504, 32'h0F0F0F0F, 0, 0, "R4 none taken");
      drive(K_JOIN, 32'h0F0F0F0F, 0, 32'h400, 0, 32'h400, 32'h0F0F0F0F, 0, 0, "R4 top still reconvergence token");
      drive(K_JOIN, 32'h0F0F0F0F, 0, 32'h404, 0, 32'h404, 32'h0F0F0F0F, 0, 1, "R4 store empty again");

      // R7 R11: call, join over return token, return
      drive(K_CALL, 32'h00FF00FF, 0, 32'h120, 32'h800, 32'h800, 32'h00FF00FF, 0, 0, "R7 call");
      drive(K_JOIN, 32'h000000FF, 0, 32'h804, 0, 32'h804, 32'h000000FF, 0, 0, "R11 join over return token");
      drive(K_RET,  32'h000000FF, 0, 32'h808, 0, 32'h120, 32'h00FF00FF, 0, 0, "R7 return");
      drive(K_RET,  32'h000000FF, 0, 32'h124, 0, 32'h124, 32'h000000FF, 0, 1, "R7 R9 return after unwind");

      // R8: fill to depth, refuse one more, unwind in order
      for (int i = 0; i < 16; i++) begin
         drive(K_CALL, 32'(i + 1), 0, 32'h1000 + 32'(i * 4), 32'h2000, 32'h2000, 32'(i + 1), 0, 0, "R8 fill");
      end
      drive(K_CALL, 32'h0000DEAD, 0, 32'h9999, 32'h2000, 32'h2000, 32'h0000DEAD, 1, 0, "R8 overflow on full");
      drive(K_SYNC, 32'h0000BEEF, 0, 32'h999C, 32'h7000, 32'h999C, 32'h0000BEEF, 1, 0, "R8 sync overflow on full");
      for (int i = 15; i >= 0; i--) begin
         drive(K_RET, 32'h0000FFFF, 0, 32'h3000, 0, 32'h1000 + 32'(i * 4), 32'(i + 1), 0, 0, "R8 unwind unchanged");
      end
      drive(K_RET, 32'h00000001, 0, 32'h3004, 0, 32'h3004, 32'h00000001, 0, 1, "R8 R9 empty after unwind");

      @(negedge clk);
      ev_kind = K_NONE;
      @(negedge clk);
      #2;
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule